// File: doc/BRIEF.md
# Matrix Keypad Scanner with Special-Function and Dedicated Keys

This block scans a key matrix of up to twelve driven rows and eight sensed columns. The column inputs idle high. It drives one enabled row low at a time and samples every enabled column. It also samples up to four dedicated key inputs, and it watches for special-function keys. A special-function key pulls its column low directly, with no row involved. Each scan pass builds a complete snapshot of all keys. A change is accepted only after the same snapshot repeats for a programmable number of passes. Accepted changes become one-byte event records in a small FIFO. The host reads the FIFO through a pop strobe.

A pass runs through these states: `ST_SFCHK`, then `ST_ROW` once per row, then `ST_EVAL`, then `ST_EMIT`.
- `ST_SFCHK` releases all rows, so any low column can only come from a special-function key.
- `ST_ROW` drives one row at a time.
- `ST_EVAL` compares the snapshot with the previous one and updates the stability count.
- `ST_EMIT` pushes one event per cycle for every key whose reported state differs from the accepted state, lowest code first.

The transitions are as follows:
- `ST_IDLE` moves to `ST_SFCHK` when `scan_run` is high. While in `ST_IDLE`, all enabled rows are held low.
- `ST_SFCHK` moves to `ST_ROW` at the end of its tick.
- `ST_ROW` moves to the next row at the end of each tick, and to `ST_EVAL` after the last row.
- `ST_EVAL` always moves to `ST_EMIT`.
- `ST_EMIT` moves, once nothing is left to report, back to `ST_SFCHK` if `scan_run` is still high, or to `ST_IDLE` if it is low.

When a special-function key is held on a column, matrix keys on that column read as released. Dedicated keys are always sampled.

Top module: `kp_matrix_scan`

## Requirements
- R1: After reset, `rd_data` is 0xFF (the no-key code), `fifo_cnt` is 0, `sf_state_n` is all ones and `key_evt` is 0. Whenever the scanner is idle (`scan_run` low and the pass finished), `row_drv_low` equals `row_en`.
- R2: While scanning, at most one bit of `row_drv_low` is set at any time.
- R3: A matrix key at row r, column c is reported with code r*8+c in bits 6:0. Bit 7 is 0 for a press and 1 for a release.
- R4: A change is reported only after the key snapshot has been identical for `db_passes`+1 consecutive passes. A press that lasts less than that produces no event.
- R5: Dedicated key k is reported with code 96+k. All four may be held at once, and each is reported.
- R6: Changes accepted together are pushed in ascending code order, so matrix keys come before dedicated keys.
- R7: A special-function key on a column c with `sf_en[c]` set shows as `sf_state_n[c]`=0 while held and 1 when released. It creates no FIFO entry.
- R8: While a special-function key on column c is held, every matrix key on column c reads as released. Keys on other columns are unaffected.
- R9: Keys on a row with `row_en` low, or on a column with `col_en` low, produce no event. A disabled row is never driven.
- R10: The FIFO holds 4 entries and `rd_pop` removes the head. A pop while empty changes nothing and `rd_data` stays 0xFF. When the FIFO is full, emission waits, so no event is lost.
- R11: `key_evt` is high for one cycle after each FIFO push and after each change of the special-function byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_run | input | 1 | Run scan passes continuously while high |
| row_en | input | 12 | Row enable mask |
| col_en | input | 8 | Column enable mask |
| sf_en | input | 8 | Columns that carry a special-function key |
| ded_en | input | 4 | Dedicated key enable mask |
| db_passes | input | 4 | Extra identical passes required before a change is accepted |
| col_in | input | 8 | Column inputs, low when a key connects them to a low source |
| ded_in | input | 4 | Dedicated key inputs, low when pressed |
| row_drv_low | output | 12 | 1 drives the row low, 0 leaves it released |
| rd_pop | input | 1 | Pop the FIFO head |
| rd_data | output | 8 | FIFO head: {released, code[6:0]}, or 0xFF when empty |
| fifo_cnt | output | 3 | Number of entries in the FIFO |
| sf_state_n | output | 8 | Special-function key byte, 1 = released |
| key_evt | output | 1 | Event pulse toward the interrupt controller |

## Verification
The bound checker watches the following on every cycle:
- the row drive: the full enabled mask when idle, and at most one row during a scan;
- the FIFO count bound;
- the no-key code whenever the FIFO is empty;
- the count decrement on a pop;
- the `key_evt` pulse after every push.

Some behaviour only the bench's scenarios can show, by pressing keys in a modelled matrix and popping the records:
- the debounce window, including a glitch that is rejected;
- the ascending order of the codes;
- column suppression while a special-function key is held;
- the masking of disabled rows and columns;
- the stall at a full FIFO.

// File: rtl/kp_pkg.sv
`timescale 1ns/1ps
package kp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SFCHK = 3'd1,
        ST_ROW   = 3'd2,
        ST_EVAL  = 3'd3,
        ST_EMIT  = 3'd4
    } scan_state_e;

    localparam int          EVT_W      = 8;
    localparam int          CODE_W     = EVT_W - 1;
    localparam logic [7:0]  NOKEY_CODE = 8'hFF;

    function automatic int safe_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/kp_scan_fsm.sv
`timescale 1ns/1ps
module kp_scan_fsm
    import kp_pkg::*;
#(
    parameter int NUM_ROWS    = 12,
    parameter int TICK_CYCLES = 4,
    localparam int RW = safe_w(NUM_ROWS),
    localparam int TW = safe_w(TICK_CYCLES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_run,
    input  logic [NUM_ROWS-1:0] row_en,
    input  logic                emit_pending,
    output scan_state_e         state,
    output logic [NUM_ROWS-1:0] row_drv_low,
    output logic [RW-1:0]       row_idx,
    output logic                sf_strobe,
    output logic                row_strobe,
    output logic                eval_strobe
);

    scan_state_e st_q, st_d;
    logic [TW-1:0] tick_q, tick_d;
    logic [RW-1:0] row_q, row_d;
    logic tick_last, row_last;

    assign tick_last = (tick_q == TW'(TICK_CYCLES - 1));
    assign row_last  = (row_q == RW'(NUM_ROWS - 1));

    always_comb begin
        st_d   = st_q;
        tick_d = tick_q;
        row_d  = row_q;
        unique case (st_q)
            ST_IDLE: begin
                if (scan_run) begin
                    st_d   = ST_SFCHK;
                    tick_d = '0;
                end
            end
            ST_SFCHK: begin
                if (tick_last) begin
                    st_d   = ST_ROW;
                    tick_d = '0;
                    row_d  = '0;
                end else begin
                    tick_d = tick_q + 1'b1;
                end
            end
            ST_ROW: begin
                if (tick_last) begin
                    tick_d = '0;
                    if (row_last) st_d = ST_EVAL;
                    else          row_d = row_q + 1'b1;
                end else begin
                    tick_d = tick_q + 1'b1;
                end
            end
            ST_EVAL: st_d = ST_EMIT;
            ST_EMIT: begin
                if (!emit_pending) begin
                    st_d   = scan_run ? ST_SFCHK : ST_IDLE;
                    tick_d = '0;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            tick_q <= '0;
            row_q  <= '0;
        end else begin
            st_q   <= st_d;
            tick_q <= tick_d;
            row_q  <= row_d;
        end
    end

    always_comb begin
        row_drv_low = '0;
        unique case (st_q)
            ST_IDLE: row_drv_low = row_en;
            ST_ROW: begin
                for (int i = 0; i < NUM_ROWS; i++)
                    row_drv_low[i] = row_en[i] && (row_q == RW'(i));
            end
            default: row_drv_low = '0;
        endcase
        sf_strobe   = (st_q == ST_SFCHK) && tick_last;
        row_strobe  = (st_q == ST_ROW) && tick_last;
        eval_strobe = (st_q == ST_EVAL);
    end

    assign state   = st_q;
    assign row_idx = row_q;

endmodule

// File: rtl/kp_debounce.sv
`timescale 1ns/1ps
module kp_debounce
    import kp_pkg::*;
#(
    parameter int NUM_ROWS = 12,
    parameter int NUM_COLS = 8,
    parameter int NUM_DED  = 4,
    parameter int DB_W     = 4,
    localparam int RW      = safe_w(NUM_ROWS),
    localparam int MAT_K   = NUM_ROWS * NUM_COLS,
    localparam int NK      = MAT_K + NUM_DED
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sf_strobe,
    input  logic                row_strobe,
    input  logic [RW-1:0]       row_idx,
    input  logic                eval_strobe,
    input  logic [NUM_ROWS-1:0] row_en,
    input  logic [NUM_COLS-1:0] col_en,
    input  logic [NUM_COLS-1:0] sf_en,
    input  logic [NUM_DED-1:0]  ded_en,
    input  logic [NUM_COLS-1:0] col_in,
    input  logic [NUM_DED-1:0]  ded_in,
    input  logic [DB_W-1:0]     db_passes,
    output logic                accept,
    output logic [NK-1:0]       acc_keys,
    output logic [NUM_COLS-1:0] acc_sf
);

    logic [NK-1:0]       snap_keys, prev_keys;
    logic [NUM_COLS-1:0] snap_sf, prev_sf;
    logic [DB_W-1:0]     stab_q;
    logic                same;
    logic [DB_W:0]       run_len;

    assign same    = (snap_keys == prev_keys) && (snap_sf == prev_sf);
    assign run_len = {1'b0, stab_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_keys <= '0;
            snap_sf   <= '0;
            prev_keys <= '0;
            prev_sf   <= '0;
            stab_q    <= '0;
        end else begin
            if (sf_strobe) begin
                snap_sf                      <= sf_en & col_en & ~col_in;
                snap_keys[MAT_K +: NUM_DED]  <= ded_en & ~ded_in;
            end
            if (row_strobe) begin
                for (int r = 0; r < NUM_ROWS; r++) begin
                    if (row_idx == RW'(r))
                        snap_keys[r*NUM_COLS +: NUM_COLS] <= row_en[r] ?
                            (col_en & ~col_in & ~(sf_en & snap_sf)) : '0;
                end
            end
            if (eval_strobe) begin
                prev_keys <= snap_keys;
                prev_sf   <= snap_sf;
                if (!same)        stab_q <= '0;
                else if (~&stab_q) stab_q <= stab_q + 1'b1;
            end
        end
    end

    assign accept   = eval_strobe &&
                      (same ? (run_len >= {1'b0, db_passes}) : (db_passes == '0));
    assign acc_keys = snap_keys;
    assign acc_sf   = snap_sf;

endmodule

// File: rtl/kp_event_enc.sv
`timescale 1ns/1ps
module kp_event_enc
    import kp_pkg::*;
#(
    parameter int NK       = 100,
    parameter int NUM_COLS = 8,
    localparam int IW      = safe_w(NK)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [NK-1:0]       acc_keys,
    input  logic [NUM_COLS-1:0] acc_sf,
    input  logic                emit_win,
    input  logic                fifo_full,
    output logic                emit_pending,
    output logic                push,
    output logic [EVT_W-1:0]    push_data,
    output logic                sf_chg,
    output logic [NUM_COLS-1:0] sf_state_n
);

    logic [NK-1:0]       tgt_q, rep_q, diff;
    logic [NUM_COLS-1:0] sf_rep_q;
    logic [IW-1:0]       sel;

    assign diff         = tgt_q ^ rep_q;
    assign emit_pending = |diff;

    always_comb begin
        sel = '0;
        for (int i = NK - 1; i >= 0; i--)
            if (diff[i]) sel = IW'(i);
    end

    assign push      = emit_win && emit_pending && !fifo_full;
    assign push_data = {~tgt_q[sel], CODE_W'(sel)};
    assign sf_chg    = accept && (acc_sf != sf_rep_q);
    assign sf_state_n = ~sf_rep_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q    <= '0;
            rep_q    <= '0;
            sf_rep_q <= '0;
        end else begin
            if (accept) begin
                tgt_q    <= acc_keys;
                sf_rep_q <= acc_sf;
            end
            if (push) rep_q[sel] <= tgt_q[sel];
        end
    end

endmodule

// File: rtl/kp_evt_fifo.sv
`timescale 1ns/1ps
module kp_evt_fifo
    import kp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW   = safe_w(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [EVT_W-1:0] push_data,
    input  logic             pop,
    output logic [EVT_W-1:0] head,
    output logic             full,
    output logic [CW-1:0]    cnt
);

    logic [EVT_W-1:0] mem [DEPTH];
    logic [PW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (cnt_q != '0);
    assign head    = (cnt_q == '0) ? NOKEY_CODE : mem[rp_q];
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/kp_matrix_scan.sv
`timescale 1ns/1ps
module kp_matrix_scan
    import kp_pkg::*;
#(
    parameter int NUM_ROWS    = 12,
    parameter int NUM_COLS    = 8,
    parameter int NUM_DED     = 4,
    parameter int TICK_CYCLES = 4,
    parameter int DB_W        = 4,
    parameter int FIFO_DEPTH  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             scan_run,
    input  logic [NUM_ROWS-1:0]              row_en,
    input  logic [NUM_COLS-1:0]              col_en,
    input  logic [NUM_COLS-1:0]              sf_en,
    input  logic [NUM_DED-1:0]               ded_en,
    input  logic [DB_W-1:0]                  db_passes,
    input  logic [NUM_COLS-1:0]              col_in,
    input  logic [NUM_DED-1:0]               ded_in,
    output logic [NUM_ROWS-1:0]              row_drv_low,
    input  logic                             rd_pop,
    output logic [EVT_W-1:0]                 rd_data,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]  fifo_cnt,
    output logic [NUM_COLS-1:0]              sf_state_n,
    output logic                             key_evt
);

    localparam int RW = safe_w(NUM_ROWS);
    localparam int NK = NUM_ROWS * NUM_COLS + NUM_DED;

    scan_state_e         st_w;
    logic [RW-1:0]       row_idx;
    logic                sf_strobe, row_strobe, eval_strobe;
    logic                accept, emit_pending, push_w, fifo_full, sf_chg;
    logic [NK-1:0]       acc_keys;
    logic [NUM_COLS-1:0] acc_sf;
    logic [EVT_W-1:0]    push_data;
    logic                key_evt_q;

    kp_scan_fsm #(.NUM_ROWS(NUM_ROWS), .TICK_CYCLES(TICK_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scan_run(scan_run), .row_en(row_en),
        .emit_pending(emit_pending), .state(st_w), .row_drv_low(row_drv_low),
        .row_idx(row_idx), .sf_strobe(sf_strobe), .row_strobe(row_strobe),
        .eval_strobe(eval_strobe)
    );

    kp_debounce #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .NUM_DED(NUM_DED),
                  .DB_W(DB_W)) u_db (
        .clk(clk), .rst_n(rst_n), .sf_strobe(sf_strobe), .row_strobe(row_strobe),
        .row_idx(row_idx), .eval_strobe(eval_strobe), .row_en(row_en),
        .col_en(col_en), .sf_en(sf_en), .ded_en(ded_en), .col_in(col_in),
        .ded_in(ded_in), .db_passes(db_passes), .accept(accept),
        .acc_keys(acc_keys), .acc_sf(acc_sf)
    );

    kp_event_enc #(.NK(NK), .NUM_COLS(NUM_COLS)) u_enc (
        .clk(clk), .rst_n(rst_n), .accept(accept), .acc_keys(acc_keys),
        .acc_sf(acc_sf), .emit_win(st_w == ST_EMIT), .fifo_full(fifo_full),
        .emit_pending(emit_pending), .push(push_w), .push_data(push_data),
        .sf_chg(sf_chg), .sf_state_n(sf_state_n)
    );

    kp_evt_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_w), .push_data(push_data),
        .pop(rd_pop), .head(rd_data), .full(fifo_full), .cnt(fifo_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_evt_q <= 1'b0;
        else        key_evt_q <= push_w || sf_chg;
    end

    assign key_evt = key_evt_q;

endmodule

// File: rtl/kp_matrix_scan_chk.sv
`timescale 1ns/1ps
module kp_matrix_scan_chk
    import kp_pkg::*;
#(
    parameter int NUM_ROWS   = 12,
    parameter int FIFO_DEPTH = 4,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input scan_state_e         st,
    input logic [NUM_ROWS-1:0] row_en,
    input logic [NUM_ROWS-1:0] row_drv_low,
    input logic                rd_pop,
    input logic                push,
    input logic [EVT_W-1:0]    rd_data,
    input logic [CW-1:0]       fifo_cnt,
    input logic                key_evt
);

    AST_IDLE_ROWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (row_drv_low == row_en)); // R1

    AST_ONE_ROW_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> $onehot0(row_drv_low)); // R2

    AST_ROW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (row_drv_low & ~row_en) == '0); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(FIFO_DEPTH)); // R10

    AST_EMPTY_NOKEY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0) |-> (rd_data == NOKEY_CODE)); // R10

    AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && fifo_cnt != '0 && !push) |=> (fifo_cnt == $past(fifo_cnt) - CW'(1))); // R10

    AST_EVT_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> key_evt); // R11

endmodule

bind kp_matrix_scan kp_matrix_scan_chk #(
    .NUM_ROWS(NUM_ROWS), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st_w), .row_en(row_en),
    .row_drv_low(row_drv_low), .rd_pop(rd_pop), .push(push_w),
    .rd_data(rd_data), .fifo_cnt(fifo_cnt), .key_evt(key_evt)
);

// File: tb/kp_matrix_scan_tb.sv
`timescale 1ns/1ps
module kp_matrix_scan_tb;

    localparam int NR = 12;
    localparam int NC = 8;
    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_run = 1'b0;
    logic [NR-1:0] row_en = '1;
    logic [NC-1:0] col_en = '1;
    logic [NC-1:0] sf_en = 8'h80;
    logic [ND-1:0] ded_en = '1;
    logic [3:0]    db_passes = 4'd2;
    logic [NC-1:0] col_in;
    logic [ND-1:0] ded_in;
    logic [NR-1:0] row_drv_low;
    logic          rd_pop = 1'b0;
    logic [7:0]    rd_data;
    logic [2:0]    fifo_cnt;
    logic [NC-1:0] sf_state_n;
    logic          key_evt;

    logic [NR*NC-1:0] mat_press = '0;
    logic [NC-1:0]    sf_press  = '0;
    logic [ND-1:0]    ded_press = '0;

    int n_chk = 0;
    int n_err = 0;
    int clk_bad = 0;
    int evt_hi = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    kp_matrix_scan u_dut (
        .clk(clk), .rst_n(rst_n), .scan_run(scan_run), .row_en(row_en),
        .col_en(col_en), .sf_en(sf_en), .ded_en(ded_en), .db_passes(db_passes),
        .col_in(col_in), .ded_in(ded_in), .row_drv_low(row_drv_low),
        .rd_pop(rd_pop), .rd_data(rd_data), .fifo_cnt(fifo_cnt),
        .sf_state_n(sf_state_n), .key_evt(key_evt)
    );

    // keypad environment: a driven row connects pressed keys to their column
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            logic low;
            low = sf_press[c];
            for (int r = 0; r < NR; r++)
                low = low | (mat_press[r*NC+c] & row_drv_low[r]);
            col_in[c] = ~low;
        end
        ded_in = ~ded_press;
    end

    // per-clock reference comparison of row drive legality and empty reads
    always @(negedge clk) begin
        if (rst_n) begin
            if (!((row_drv_low == row_en) ||
                  ($onehot0(row_drv_low) && ((row_drv_low & ~row_en) == '0))))
                clk_bad++;
            if (fifo_cnt == 3'd0 && rd_data != 8'hFF) clk_bad++;
            if (fifo_cnt > 3'd4) clk_bad++;
        end
    end

    always @(posedge clk) if (key_evt) evt_hi++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string tag);
        @(negedge clk);
        check(rd_data == exp, tag, rd_data, exp);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        wait_cyc(6);
    endtask

    function automatic int key(input int r, input int c);
        return r * NC + c;
    endfunction

    initial begin
        int base;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 8'hFF, "R1 rd_data", rd_data, 8'hFF);
        check(fifo_cnt == 3'd0, "R1 fifo_cnt", fifo_cnt, 0);
        check(sf_state_n == 8'hFF, "R1 sf_state_n", sf_state_n, 8'hFF);
        check(key_evt == 1'b0, "R1 key_evt", key_evt, 0);
        check(row_drv_low == row_en, "R1 idle rows", row_drv_low, row_en);

        scan_run = 1'b1;
        wait_cyc(200);

        // R3 single press / release, R11 pulse count
        base = evt_hi;
        mat_press[key(2,3)] = 1'b1;
        wait_cyc(400);
        check(evt_hi - base == 1, "R11 one pulse per push", evt_hi - base, 1);
        pop_expect(8'h13, "R3 press code");
        mat_press[key(2,3)] = 1'b0;
        wait_cyc(400);
        pop_expect(8'h93, "R3 release code");

        // R6 simultaneous changes in ascending order
        mat_press[key(5,1)] = 1'b1;
        mat_press[key(0,0)] = 1'b1;
        wait_cyc(400);
        pop_expect(8'h00, "R6 first");
        pop_expect(8'h29, "R6 second");
        mat_press[key(5,1)] = 1'b0;
        mat_press[key(0,0)] = 1'b0;
        wait_cyc(400);
        pop_expect(8'h80, "R6 release first");
        pop_expect(8'hA9, "R6 release second");

        // R4 short glitch rejected
        mat_press[key(1,1)] = 1'b1;
        wait_cyc(60);
        mat_press[key(1,1)] = 1'b0;
        wait_cyc(400);
        check(fifo_cnt == 3'd0, "R4 glitch ignored", fifo_cnt, 0);

        // R5 dedicated keys, R10 stall on full FIFO
        ded_press = 4'hF;
        mat_press[key(3,2)] = 1'b1;
        wait_cyc(400);
        check(fifo_cnt == 3'd4, "R10 fifo full", fifo_cnt, 4);
        pop_expect(8'h1A, "R6 matrix before dedicated");
        pop_expect(8'h60, "R5 ded0");
        pop_expect(8'h61, "R5 ded1");
        pop_expect(8'h62, "R5 ded2");
        pop_expect(8'h63, "R10 stalled entry kept");
        ded_press = 4'h0;
        mat_press[key(3,2)] = 1'b0;
        wait_cyc(400);
        pop_expect(8'h9A, "R3 release 3,2");
        pop_expect(8'hE0, "R5 ded0 release");
        pop_expect(8'hE1, "R5 ded1 release");
        pop_expect(8'hE2, "R5 ded2 release");
        pop_expect(8'hE3, "R5 ded3 release");

        // R7 / R8 special-function key on column 7
        mat_press[key(4,7)] = 1'b1;
        wait_cyc(400);
        pop_expect(8'h27, "R3 press 4,7");
        base = evt_hi;
        sf_press[7] = 1'b1;
        mat_press[key(4,6)] = 1'b1;
        wait_cyc(400);
        check(sf_state_n == 8'h7F, "R7 sf held", sf_state_n, 8'h7F);
        check(evt_hi - base == 3, "R11 sf change plus pushes", evt_hi - base, 3);
        pop_expect(8'h26, "R8 other column unaffected");
        pop_expect(8'hA7, "R8 column suppressed");
        check(fifo_cnt == 3'd0, "R7 no sf entry", fifo_cnt, 0);
        sf_press[7] = 1'b0;
        wait_cyc(400);
        check(sf_state_n == 8'hFF, "R7 sf released", sf_state_n, 8'hFF);
        pop_expect(8'h27, "R8 column restored");
        mat_press[key(4,7)] = 1'b0;
        mat_press[key(4,6)] = 1'b0;
        wait_cyc(400);
        pop_expect(8'hA6, "R3 release 4,6");
        pop_expect(8'hA7, "R3 release 4,7");

        // R9 disabled row and column
        col_en[2] = 1'b0;
        row_en[9] = 1'b0;
        mat_press[key(6,2)] = 1'b1;
        mat_press[key(9,0)] = 1'b1;
        mat_press[key(6,3)] = 1'b1;
        wait_cyc(400);
        check(fifo_cnt == 3'd1, "R9 only enabled key", fifo_cnt, 1);
        pop_expect(8'h33, "R9 enabled key code");
        check(fifo_cnt == 3'd0, "R9 masked keys silent", fifo_cnt, 0);
        mat_press = '0;
        wait_cyc(400);
        pop_expect(8'hB3, "R9 enabled release");
        col_en = '1;
        row_en = '1;
        wait_cyc(400);
        check(fifo_cnt == 3'd0, "R9 restore silent", fifo_cnt, 0);

        // R10 pop while empty
        pop_expect(8'hFF, "R10 empty nokey");
        check(fifo_cnt == 3'd0, "R10 empty pop", fifo_cnt, 0);

        // R1 back to idle
        scan_run = 1'b0;
        wait_cyc(200);
        check(row_drv_low == row_en, "R1 idle rows after stop", row_drv_low, row_en);

        // R2 per-clock row drive comparison
        check(clk_bad == 0, "R2 per-clock row drive", clk_bad, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R10 actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule